// File: doc/BRIEF.md
# Hot-Plug Driven Two-Port Sink Selector

This block decides which of two display sink ports is connected to a single video source. It watches the hot-plug level of each sink and a selection mode. In automatic mode the sink that is plugged in wins, and a priority code settles the case where both are plugged in. In the manual modes a port is forced, or both ports are turned off. The block drives a one-hot port enable, the hot-plug line and the cable-detect line back to the source, and a power-down request. The analog switches, the re-driver and the register interface sit outside the block. Its outputs drive them, and its option inputs come from them.

Any change of connection passes through a timed gap. During the gap no port is enabled, the source hot-plug line is driven low and the cable-detect line is released. The source therefore sees a clean unplug and replug. A short low pulse on the active sink's hot-plug line is passed to the source as an interrupt and does not move the selection. All timers count a one-millisecond tick. Option inputs pick a long or short value for each timer and apply a common -25 % / +25 % scale.

Top module: `hpd_port_selector`

## Requirements
- R1: With `sel_mode` = 2'b11 (automatic), when only one synchronised hot-plug input is high and no port is enabled, that port is enabled once the gap of R4 has ended. `port_en` bit 0 is port 1 and bit 1 is port 2.
- R2: In automatic mode with both hot-plug inputs high, port 2 is preferred when `prio_code[2]` = 1 or `prio_code` = 3'b011, and port 1 otherwise. A change of the preferred port moves the connection through the gap of R4.
- R3: `sel_mode` 2'b00 forces port 1 and 2'b10 forces port 2, whatever the hot-plug levels. 2'b01 turns every output off on the next clock, and 2'b11 selects automatically.
- R4: Every enable of a port from the no-port state, and every port change except the one in R9, is preceded by a gap of t3 ticks. During the gap `port_en` = 0, `src_hpd_oe` = 1, `src_hpd` = 0 and `src_cab_oe` = 0. t3 is 256 ms, or 128 ms when `t3_short` = 1. When the gap ends the selection is evaluated again, and the block goes idle if nothing is selected.
- R5: While a port is active in automatic mode, its hot-plug input being low for fewer than t1 + t2 ticks does not change the port, and `src_hpd` follows the low level as an interrupt. t1 is 2 ms, or 4 ms when `t1_long` = 1. t2 is 125 ms.
- R6: When the active port's hot-plug input stays low for t1 + t2 ticks while the other port's input is high, the block starts the gap of R4 and then enables the other port. If the other input is low, the active port stays enabled.
- R7: `pwr_down_req` rises once both hot-plug inputs have been low for t4 ticks. It clears on the clock after either input is high again. t4 is 1024 ms, or 516 ms when `t4_short` = 1.
- R8: `tscale` = 2'b01 makes every timer value floor(3/4 × nominal) and 2'b10 makes it floor(5/4 × nominal). 2'b00 and 2'b11 keep the nominal values. For the t1 + t2 window, each term is scaled on its own.
- R9: With `skip_gap` = 1 in manual mode 2'b00 or 2'b10, moving from one port to the other takes effect on the next clock with no gap. In automatic mode, and when leaving the no-port state, `skip_gap` has no effect.
- R10: While port 1 is active, `src_cab` follows the synchronised `cab1_in`. While port 2 is active, `src_cab` = 1. `src_cab_oe` = 1 only while a port is active. In the idle state both `src_hpd_oe` and `src_cab_oe` are 0, and this is also the state after reset.
- R11: With `hpd_invert` = 1, `src_hpd` is the complement of the active port's synchronised hot-plug level. The gap still drives 0.
- R12: `out_disable` = 1 forces the idle no-port state on the next clock. After release, the selection is evaluated again and goes through the gap of R4 before any port is enabled.
- R13: `hpd1_in`, `hpd2_in` and `cab1_in` pass through two flops. A change shows at the outputs after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| hpd1_in | input | 1 | Hot-plug level from sink port 1 (asynchronous) |
| hpd2_in | input | 1 | Hot-plug level from sink port 2 (asynchronous) |
| cab1_in | input | 1 | Cable-detect level from sink port 1 (asynchronous) |
| prio_code | input | 3 | Priority code for automatic mode |
| sel_mode | input | 2 | 00 port 1, 01 off, 10 port 2, 11 automatic |
| t1_long | input | 1 | Interrupt window t1 = 4 ms instead of 2 ms |
| t3_short | input | 1 | Gap t3 = 128 ms instead of 256 ms |
| t4_short | input | 1 | Power-down delay t4 = 516 ms instead of 1024 ms |
| tscale | input | 2 | Timer scale: 01 = -25 %, 10 = +25 % |
| skip_gap | input | 1 | Skip the gap on manual port changes |
| hpd_invert | input | 1 | Invert the hot-plug level sent to the source |
| out_disable | input | 1 | Standby / output disable, forces idle |
| port_en | output | 2 | One-hot port enable, 0 = no port |
| src_hpd | output | 1 | Hot-plug level to the source |
| src_hpd_oe | output | 1 | Drive enable for `src_hpd` |
| src_cab | output | 1 | Cable-detect level to the source |
| src_cab_oe | output | 1 | Drive enable for `src_cab` |
| pwr_down_req | output | 1 | Request to power the switch down |

## Verification
The hot-plug patterns are:
- one sink plugged into an idle selector, which shows the gap before the first enable;
- both sinks plugged with each priority code, which shows the preference and that a preference change passes through the gap;
- a short and a long low pulse on the active sink while the other sink stays plugged, which separates an interrupt from a real unplug that moves the port after t1 + t2;
- both sinks unplugged, which shows that the port stays enabled and that the power-down request follows after t4.

Manual modes are driven with and without the gap-skip bit, and the skip is also set in automatic mode to show it changes nothing there. The timer option and scale bits are changed between phases. A behavioural model therefore checks the exact tick on which each gap, switch and request happens for several limit values, not only the nominal ones.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_GAP  = 2'b01,
    ST_ACT  = 2'b10
  } hps_state_e;

  localparam logic [1:0] MODE_P1   = 2'b00;
  localparam logic [1:0] MODE_OFF  = 2'b01;
  localparam logic [1:0] MODE_P2   = 2'b10;
  localparam logic [1:0] MODE_AUTO = 2'b11;

  // scale a nominal millisecond value, rounding down
  function automatic int unsigned hps_scale(input int unsigned v, input logic [1:0] sc);
    case (sc)
      2'b01:   return (v * 3) / 4;
      2'b10:   return (v * 5) / 4;
      default: return v;
    endcase
  endfunction

  // one-hot choice from two plug levels and a preference
  function automatic logic [1:0] hps_pick(input logic e1, input logic e2, input logic p2_first);
    if (e1 && e2)  return p2_first ? 2'b10 : 2'b01;
    else if (e1)   return 2'b01;
    else if (e2)   return 2'b10;
    else           return 2'b00;
  endfunction

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1;
    logic s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end

endmodule

// File: rtl/hps_limits.sv
module hps_limits
  import hps_pkg::*;
#(
  parameter int unsigned T1_SHORT_MS = 2,
  parameter int unsigned T1_LONG_MS  = 4,
  parameter int unsigned T2_MS       = 125,
  parameter int unsigned T3_LONG_MS  = 256,
  parameter int unsigned T3_SHORT_MS = 128,
  parameter int unsigned T4_LONG_MS  = 1024,
  parameter int unsigned T4_SHORT_MS = 516,
  parameter int unsigned CW          = 12
) (
  input  logic          t1_long,
  input  logic          t3_short,
  input  logic          t4_short,
  input  logic [1:0]    tscale,
  output logic [CW-1:0] t12_lim,
  output logic [CW-1:0] t3_lim,
  output logic [CW-1:0] t4_lim
);

  int unsigned t1_nom;
  int unsigned t3_nom;
  int unsigned t4_nom;

  always_comb begin
    t1_nom  = t1_long  ? T1_LONG_MS  : T1_SHORT_MS;
    t3_nom  = t3_short ? T3_SHORT_MS : T3_LONG_MS;
    t4_nom  = t4_short ? T4_SHORT_MS : T4_LONG_MS;
    t12_lim = CW'(hps_scale(t1_nom, tscale) + hps_scale(T2_MS, tscale));
    t3_lim  = CW'(hps_scale(t3_nom, tscale));
    t4_lim  = CW'(hps_scale(t4_nom, tscale));
  end

endmodule

// File: rtl/hps_idle_timer.sv
module hps_idle_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hpd_any,
  input  logic [CW-1:0] lim,
  output logic          req
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (hpd_any) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick && (cnt_q < lim)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign req = (cnt_q >= lim);

  AST_PWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_any |=> !req); // R7

endmodule

// File: rtl/hpd_port_selector.sv
module hpd_port_selector
  import hps_pkg::*;
#(
  parameter int unsigned T1_SHORT_MS = 2,
  parameter int unsigned T1_LONG_MS  = 4,
  parameter int unsigned T2_MS       = 125,
  parameter int unsigned T3_LONG_MS  = 256,
  parameter int unsigned T3_SHORT_MS = 128,
  parameter int unsigned T4_LONG_MS  = 1024,
  parameter int unsigned T4_SHORT_MS = 516
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       hpd1_in,
  input  logic       hpd2_in,
  input  logic       cab1_in,
  input  logic [2:0] prio_code,
  input  logic [1:0] sel_mode,
  input  logic       t1_long,
  input  logic       t3_short,
  input  logic       t4_short,
  input  logic [1:0] tscale,
  input  logic       skip_gap,
  input  logic       hpd_invert,
  input  logic       out_disable,
  output logic [1:0] port_en,
  output logic       src_hpd,
  output logic       src_hpd_oe,
  output logic       src_cab,
  output logic       src_cab_oe,
  output logic       pwr_down_req
);

  localparam int unsigned TMAX = ((T4_LONG_MS + T3_LONG_MS + T2_MS + T1_LONG_MS) * 5) / 4;
  localparam int unsigned CW   = $clog2(TMAX + 1);

  // input synchronisation: bit0 hpd1, bit1 hpd2, bit2 cab1
  logic [2:0] sync_q;
  logic       h1;
  logic       h2;
  logic       cab_s;

  hps_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cab1_in, hpd2_in, hpd1_in}),
    .q     (sync_q)
  );

  assign h1    = sync_q[0];
  assign h2    = sync_q[1];
  assign cab_s = sync_q[2];

  logic [CW-1:0] t12_lim;
  logic [CW-1:0] t3_lim;
  logic [CW-1:0] t4_lim;

  hps_limits #(
    .T1_SHORT_MS (T1_SHORT_MS),
    .T1_LONG_MS  (T1_LONG_MS),
    .T2_MS       (T2_MS),
    .T3_LONG_MS  (T3_LONG_MS),
    .T3_SHORT_MS (T3_SHORT_MS),
    .T4_LONG_MS  (T4_LONG_MS),
    .T4_SHORT_MS (T4_SHORT_MS),
    .CW          (CW)
  ) u_limits (
    .t1_long  (t1_long),
    .t3_short (t3_short),
    .t4_short (t4_short),
    .tscale   (tscale),
    .t12_lim  (t12_lim),
    .t3_lim   (t3_lim),
    .t4_lim   (t4_lim)
  );

  hps_idle_timer #(.CW(CW)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ms_tick),
    .hpd_any (h1 | h2),
    .lim     (t4_lim),
    .req     (pwr_down_req)
  );

  // selection state
  hps_state_e    st_q, st_d;
  logic [1:0]    act_q, act_d;
  logic [CW-1:0] gap_q, gap_d;
  logic [CW-1:0] low_q, low_d;

  logic       p2_first;
  logic [1:0] man_pick;
  logic [1:0] idle_pick;
  logic       hpd_act;
  logic       eff_act;
  logic [1:0] act_pick;
  logic       is_act;

  always_comb begin
    p2_first  = prio_code[2] | (prio_code[1:0] == 2'b11);
    man_pick  = sel_mode[1] ? 2'b10 : 2'b01;
    case (sel_mode)
      MODE_AUTO: idle_pick = hps_pick(h1, h2, p2_first);
      MODE_OFF:  idle_pick = 2'b00;
      default:   idle_pick = man_pick;
    endcase
    hpd_act  = |(act_q & {h2, h1});
    eff_act  = hpd_act | (low_q < t12_lim);
    act_pick = hps_pick(act_q[0] ? eff_act : h1,
                        act_q[1] ? eff_act : h2,
                        p2_first);
  end

  // next-state process
  always_comb begin
    st_d  = st_q;
    act_d = act_q;
    gap_d = gap_q;
    low_d = low_q;
    if (out_disable) begin
      st_d  = ST_IDLE;
      act_d = 2'b00;
      gap_d = '0;
      low_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (idle_pick != 2'b00) begin
            st_d  = ST_GAP;
            gap_d = '0;
          end
        end
        ST_GAP: begin
          if (ms_tick) begin
            if (gap_q >= t3_lim - CW'(1)) begin
              gap_d = '0;
              low_d = '0;
              act_d = idle_pick;
              st_d  = (idle_pick == 2'b00) ? ST_IDLE : ST_ACT;
            end else begin
              gap_d = gap_q + CW'(1);
            end
          end
        end
        ST_ACT: begin
          if (hpd_act)                             low_d = '0;
          else if (ms_tick && (low_q < t12_lim))   low_d = low_q + CW'(1);
          if (sel_mode == MODE_OFF) begin
            st_d  = ST_IDLE;
            act_d = 2'b00;
            low_d = '0;
          end else if (sel_mode == MODE_AUTO) begin
            if ((act_pick != 2'b00) && (act_pick != act_q)) begin
              st_d  = ST_GAP;
              act_d = 2'b00;
              gap_d = '0;
            end
          end else if (man_pick != act_q) begin
            if (skip_gap) begin
              act_d = man_pick;
              low_d = '0;
            end else begin
              st_d  = ST_GAP;
              act_d = 2'b00;
              gap_d = '0;
            end
          end
        end
        default: begin
          st_d  = ST_IDLE;
          act_d = 2'b00;
        end
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      act_q <= 2'b00;
      gap_q <= '0;
      low_q <= '0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
      gap_q <= gap_d;
      low_q <= low_d;
    end
  end

  // outputs
  assign is_act     = (st_q == ST_ACT);
  assign port_en    = is_act ? act_q : 2'b00;
  assign src_hpd_oe = (st_q != ST_IDLE);
  assign src_hpd    = is_act & (hpd_act ^ hpd_invert);
  assign src_cab_oe = is_act;
  assign src_cab    = is_act & (act_q[1] | cab_s);

  AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_en)); // R1

  AST_GAP_BEFORE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(port_en) == 2'b00) && (port_en != 2'b00)) |-> $past(src_hpd_oe && !src_hpd && !src_cab_oe)); // R4

  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_en != 2'b00) && ($past(port_en) != 2'b00) && (port_en != $past(port_en)))
      |-> $past(skip_gap && !sel_mode[0])); // R9

  AST_GAP_HPD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (src_hpd_oe && (port_en == 2'b00)) |-> (!src_hpd && !src_cab_oe)); // R4

  AST_CAB_PORT2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en == 2'b10) |-> (src_cab && src_cab_oe)); // R10

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |=> ((port_en == 2'b00) && !src_hpd_oe && !src_cab_oe)); // R12

  AST_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mode == MODE_OFF) |=> (port_en == 2'b00)); // R3

endmodule

// File: tb/sim_hpd_port_selector.sv
module sim_hpd_port_selector;

  logic       clk;
  logic       rst_n;
  logic       ms_tick;
  logic       hpd1_in, hpd2_in, cab1_in;
  logic [2:0] prio_code;
  logic [1:0] sel_mode;
  logic       t1_long, t3_short, t4_short;
  logic [1:0] tscale;
  logic       skip_gap, hpd_invert, out_disable;
  logic [1:0] port_en;
  logic       src_hpd, src_hpd_oe, src_cab, src_cab_oe, pwr_down_req;

  hpd_port_selector u0 (
    .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick),
    .hpd1_in (hpd1_in), .hpd2_in (hpd2_in), .cab1_in (cab1_in),
    .prio_code (prio_code), .sel_mode (sel_mode),
    .t1_long (t1_long), .t3_short (t3_short), .t4_short (t4_short),
    .tscale (tscale), .skip_gap (skip_gap), .hpd_invert (hpd_invert),
    .out_disable (out_disable), .port_en (port_en), .src_hpd (src_hpd),
    .src_hpd_oe (src_hpd_oe), .src_cab (src_cab), .src_cab_oe (src_cab_oe),
    .pwr_down_req (pwr_down_req)
  );

  int    tests;
  int    fails;
  bit    done;
  bit    run_cmp;
  string phase;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // millisecond tick: one cycle in four
  initial begin
    ms_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  // ---------------- behavioural reference model ----------------
  int m_st;   // 0 idle, 1 gap, 2 active
  int m_port; // 0 none, 1, 2
  int m_gap, m_low, m_idle;
  bit m_a1, m_a2, m_ac, m_h1, m_h2, m_c;
  int n_st, n_port, n_gap, n_low, want, apick, lim12, lim3, lim4;
  bit hact, e1, e2;

  function automatic int scl(input int v);
    if (tscale == 2'b01) return (v * 3) / 4;
    if (tscale == 2'b10) return (v * 5) / 4;
    return v;
  endfunction

  function automatic int choose(input bit a, input bit b);
    bit pref2;
    pref2 = prio_code[2] || (prio_code == 3'b011);
    if (a && b) return pref2 ? 2 : 1;
    if (a) return 1;
    if (b) return 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_port = 0; m_gap = 0; m_low = 0; m_idle = 0;
      m_a1 = 0; m_a2 = 0; m_ac = 0; m_h1 = 0; m_h2 = 0; m_c = 0;
    end else begin
      lim12 = scl(t1_long ? 4 : 2) + scl(125);
      lim3  = scl(t3_short ? 128 : 256);
      lim4  = scl(t4_short ? 516 : 1024);
      if (sel_mode == 2'b11)      want = choose(m_h1, m_h2);
      else if (sel_mode == 2'b01) want = 0;
      else if (sel_mode == 2'b10) want = 2;
      else                        want = 1;
      n_st = m_st; n_port = m_port; n_gap = m_gap; n_low = m_low;
      if (out_disable) begin
        n_st = 0; n_port = 0; n_gap = 0; n_low = 0;
      end else if (m_st == 0) begin
        if (want != 0) begin n_st = 1; n_gap = 0; end
      end else if (m_st == 1) begin
        if (ms_tick) begin
          if (m_gap >= lim3 - 1) begin
            n_gap = 0; n_low = 0; n_port = want;
            n_st = (want == 0) ? 0 : 2;
          end else n_gap = m_gap + 1;
        end
      end else begin
        hact = (m_port == 1) ? m_h1 : m_h2;
        if (hact) n_low = 0;
        else if (ms_tick && m_low < lim12) n_low = m_low + 1;
        if (sel_mode == 2'b01) begin
          n_st = 0; n_port = 0; n_low = 0;
        end else if (sel_mode == 2'b11) begin
          e1 = (m_port == 1) ? (hact || m_low < lim12) : m_h1;
          e2 = (m_port == 2) ? (hact || m_low < lim12) : m_h2;
          apick = choose(e1, e2);
          if (apick != 0 && apick != m_port) begin n_st = 1; n_port = 0; n_gap = 0; end
        end else if (want != m_port) begin
          if (skip_gap) begin n_port = want; n_low = 0; end
          else begin n_st = 1; n_port = 0; n_gap = 0; end
        end
      end
      if (m_h1 || m_h2) m_idle = 0;
      else if (ms_tick && m_idle < lim4) m_idle = m_idle + 1;
      m_st = n_st; m_port = n_port; m_gap = n_gap; m_low = n_low;
      m_h1 = m_a1; m_h2 = m_a2; m_c = m_ac;
      m_a1 = hpd1_in; m_a2 = hpd2_in; m_ac = cab1_in;
    end
  end

  // per-cycle comparison, 1 ns after the rising edge
  logic [6:0] exp_v, act_v;
  always @(posedge clk) begin
    #1;
    if (rst_n && run_cmp && !done) begin
      exp_v[6:5] = (m_st == 2) ? ((m_port == 1) ? 2'b01 : 2'b10) : 2'b00;
      exp_v[4]   = (m_st == 2) && (((m_port == 1) ? m_h1 : m_h2) ^ hpd_invert);
      exp_v[3]   = (m_st != 0);
      exp_v[2]   = (m_st == 2) && ((m_port == 2) || m_c);
      exp_v[1]   = (m_st == 2);
      exp_v[0]   = (m_idle >= scl(t4_short ? 516 : 1024));
      act_v = {port_en, src_hpd, src_hpd_oe, src_cab, src_cab_oe, pwr_down_req};
      tests++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s model compare: actual=%b expected=%b", phase, act_v, exp_v);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] a, input logic [7:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic wait_ms(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tests = 0; fails = 0; done = 0; run_cmp = 0; phase = "reset";
    rst_n = 0; hpd1_in = 0; hpd2_in = 0; cab1_in = 0;
    prio_code = 3'b000; sel_mode = 2'b11;
    t1_long = 0; t3_short = 0; t4_short = 0; tscale = 2'b00;
    skip_gap = 0; hpd_invert = 0; out_disable = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);
    // R10: idle after reset, nothing driven
    chk("R10 reset", {5'b0, port_en, src_hpd_oe}, 8'h00);
    chk("R10 reset cab", {6'b0, src_cab_oe, pwr_down_req}, 8'h00);

    // R1 / R4: single sink plugged into idle selector
    phase = "R1";
    hpd1_in = 1;
    wait_ms(100);
    chk("R4 gap port off", {6'b0, port_en}, 8'h00);
    chk("R4 gap hpd low", {6'b0, src_hpd_oe, src_hpd}, 8'h02);
    wait_ms(170);
    chk("R1 port1 enabled", {6'b0, port_en}, 8'h01);

    // R13 / R10: cable detect through two flops
    phase = "R13";
    cab1_in = 1;
    @(negedge clk);
    chk("R13 one edge, old value", {7'b0, src_cab}, 8'h00);
    @(negedge clk);
    chk("R13 two edges, new value", {7'b0, src_cab}, 8'h01);
    chk("R10 cab follows port1", {6'b0, src_cab_oe, src_cab}, 8'h03);
    cab1_in = 0;
    wait_ms(1);

    // R5: short interrupt pulse
    phase = "R5";
    hpd1_in = 0;
    wait_ms(1);
    chk("R5 irq passes", {5'b0, port_en, src_hpd}, 8'h02);
    hpd1_in = 1;
    wait_ms(1);
    chk("R5 irq ends", {5'b0, port_en, src_hpd}, 8'h03);

    // R2: both plugged, port1 first
    phase = "R2";
    hpd2_in = 1; prio_code = 3'b000;
    wait_ms(10);
    chk("R2 prio 000 keeps port1", {6'b0, port_en}, 8'h01);
    // R5: long pulse below t1+t2 with port2 plugged
    phase = "R5";
    hpd1_in = 0;
    wait_ms(100);
    chk("R5 100ms low keeps port1", {5'b0, port_en, src_hpd}, 8'h02);
    hpd1_in = 1;
    wait_ms(2);
    // R11: inversion
    phase = "R11";
    hpd_invert = 1;
    @(negedge clk);
    chk("R11 inverted hpd", {7'b0, src_hpd}, 8'h00);
    hpd_invert = 0;
    @(negedge clk);
    chk("R11 plain hpd", {7'b0, src_hpd}, 8'h01);

    // R2: preference to port 2
    phase = "R2";
    prio_code = 3'b011;
    wait_ms(10);
    chk("R2 prio 011 opens gap", {6'b0, port_en}, 8'h00);
    wait_ms(260);
    chk("R2 prio 011 selects port2", {6'b0, port_en}, 8'h02);
    chk("R10 cab high on port2", {6'b0, src_cab_oe, src_cab}, 8'h03);
    prio_code = 3'b100;
    wait_ms(5);
    chk("R2 prio 100 keeps port2", {6'b0, port_en}, 8'h02);
    prio_code = 3'b010;
    wait_ms(270);
    chk("R2 prio 010 back to port1", {6'b0, port_en}, 8'h01);

    // R6: real unplug of active port, other plugged
    phase = "R6";
    hpd1_in = 0;
    wait_ms(100);
    chk("R6 before t1+t2", {6'b0, port_en}, 8'h01);
    wait_ms(40);
    chk("R6 gap after t1+t2", {6'b0, port_en}, 8'h00);
    wait_ms(260);
    chk("R6 moved to port2", {6'b0, port_en}, 8'h02);

    // R3: manual modes
    phase = "R3";
    sel_mode = 2'b00;
    wait_ms(5);
    chk("R3 manual port1 gap", {6'b0, port_en}, 8'h00);
    wait_ms(260);
    chk("R3 manual port1", {6'b0, port_en}, 8'h01);
    phase = "R9";
    skip_gap = 1;
    sel_mode = 2'b10;
    @(negedge clk);
    chk("R9 skip to port2", {6'b0, port_en}, 8'h02);
    sel_mode = 2'b00;
    @(negedge clk);
    chk("R9 skip to port1", {6'b0, port_en}, 8'h01);
    phase = "R3";
    sel_mode = 2'b01;
    @(negedge clk);
    chk("R3 off mode", {5'b0, port_en, src_hpd_oe}, 8'h00);
    sel_mode = 2'b11;
    wait_ms(270);
    chk("R3 auto picks port2", {6'b0, port_en}, 8'h02);
    phase = "R9";
    hpd1_in = 1; prio_code = 3'b000;
    wait_ms(5);
    chk("R9 skip ignored in auto", {6'b0, port_en}, 8'h00);
    wait_ms(270);
    chk("R9 auto then port1", {6'b0, port_en}, 8'h01);
    skip_gap = 0;

    // R12: output disable
    phase = "R12";
    out_disable = 1;
    @(negedge clk);
    chk("R12 disable idles", {5'b0, port_en, src_hpd_oe}, 8'h00);
    wait_ms(5);
    out_disable = 0;
    wait_ms(5);
    chk("R12 release gap", {5'b0, port_en, src_hpd_oe}, 8'h01);
    wait_ms(260);
    chk("R12 release port1", {6'b0, port_en}, 8'h01);

    // R7: power-down request
    phase = "R7";
    hpd1_in = 0; hpd2_in = 0;
    wait_ms(1000);
    chk("R7 before t4", {7'b0, pwr_down_req}, 8'h00);
    chk("R6 port kept with nothing plugged", {6'b0, port_en}, 8'h01);
    wait_ms(30);
    chk("R7 after t4", {7'b0, pwr_down_req}, 8'h01);
    hpd2_in = 1;
    wait_ms(1);
    chk("R7 clears on plug", {7'b0, pwr_down_req}, 8'h00);
    hpd2_in = 0;

    // R8: scaled timers
    phase = "R8";
    t4_short = 1; tscale = 2'b01;
    wait_ms(370);
    chk("R8 t4 -25% before", {7'b0, pwr_down_req}, 8'h00);
    wait_ms(25);
    chk("R8 t4 -25% after", {7'b0, pwr_down_req}, 8'h01);
    tscale = 2'b10; t3_short = 1; t1_long = 1;
    hpd1_in = 1;
    wait_ms(150);
    chk("R8 t3 +25% still gap", {6'b0, port_en}, 8'h00);
    wait_ms(15);
    chk("R8 t3 +25% done", {6'b0, port_en}, 8'h01);
    wait_ms(5);

    finish_run();
  end

endmodule